// File: doc/BRIEF.md
# Dual-Channel Phase-Offset Sine Synthesizer

This core produces two streams of sine samples at the same frequency, with a programmable phase difference between them. A host sets three control words through a single-cycle register-write port: a 32-bit tuning word, a phase difference in whole degrees, and an 8-bit amplitude. The written values are held in shadow registers and have no effect until an apply strobe arrives.

Each channel has a 32-bit phase accumulator that adds the shared tuning word on every clock. The top 8 bits of the accumulator address a 256-entry sine table. The table entry is scaled about midscale by the amplitude word, and the result is registered as an 8-bit offset-binary sample for an external DAC. The apply strobe restarts both accumulators on the same edge: channel A starts at zero and channel B starts at the offset that matches the programmed degree value. The two channels then keep a constant phase difference.

At a reference clock of f_clk, the output frequency is K·f_clk/2^32. This fine resolution lets a host reach audio frequencies such as 20 Hz to 20 kHz in 20 Hz steps.

Top module: `dual_dds_core`

## Requirements
- R1: While reset is low, and after reset is released, both sample outputs equal 128. After reset the active tuning word, the shadow tuning word, both accumulators and the degree value are 0, and the amplitude is 255.
- R2: A write with `wr_en_i` high stores `wr_data_i` into a shadow register selected by `wr_addr_i`. Address 0 takes the tuning word (all 32 bits), address 1 takes degrees and address 2 takes the amplitude (bits 7:0). Address 3 is ignored. Shadow values change neither output until `apply_i` is asserted.
- R3: Between apply strobes, each accumulator increases by the active tuning word K on every clock, modulo 2^32. For a K that divides 2^32, each output therefore repeats every 2^32/K cycles.
- R4: The sine table entry at address a is round(128 + 127·sin(2πa/256)). The address is bits 31:24 of the accumulator.
- R5: On a clock edge where `apply_i` is high, the shadows are copied to the active registers. On that same edge accumulator A is set to 0 and accumulator B is set to round(d·2^32/360), where d is the shadow degree value. A shadow write on the same edge is not seen by that apply.
- R6: A degree write with a value above 359 is dropped, and the shadow keeps its previous value.
- R7: Each output sample equals ((t−128)·amp >>> 8) + 128, where t is the table entry, amp is the active amplitude and >>> is an arithmetic (floor) shift. The result is registered, so the sample from accumulator value v appears one clock after v is held. With amplitude 0, both outputs hold 128.
- R8: Both channels use the same active tuning word. Their accumulator difference stays constant from one apply to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Shadow register select (0 tuning, 1 degrees, 2 amplitude) |
| wr_data_i | input | 32 | Write data |
| apply_i | input | 1 | Copy shadows to active registers and restart both accumulators |
| samp_a_o | output | 8 | Channel A sample, offset binary |
| samp_b_o | output | 8 | Channel B sample, offset binary |

## Verification
Two situations are hardest to observe from the ports alone.

The first is the lead of channel B over channel A. At small degree values it moves the table address by less than one step. It only shows up when an accumulator carry reaches bit 24 in one channel before the other. The stimulus therefore pairs a 1-degree offset with a small tuning word and checks every sample against a cycle-exact model of both accumulators.

The second is wrap-around. Large tuning words, including one close to 2^32, force the accumulators to overflow on almost every clock. A tuning word of 2^24 is used to show the exact 256-cycle repeat.

Rejected degree values and writes that are never applied are proven harmless by letting the old sequence continue and comparing it sample for sample.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int ACC_W    = 32;
  localparam int LUT_AW   = 8;
  localparam int SAMP_W   = 8;
  localparam int AMP_W    = 8;
  localparam int DEG_W    = 9;
  localparam int DEG_FULL = 360;

  typedef enum logic [1:0] {
    REG_TUNE = 2'd0,
    REG_DEG  = 2'd1,
    REG_AMP  = 2'd2
  } reg_sel_e;

  // round(d * 2^ACC_W / 360)
  function automatic logic [ACC_W-1:0] deg_to_ofs(input logic [DEG_W-1:0] d);
    logic [ACC_W+DEG_W-1:0] num;
    num = {d, {ACC_W{1'b0}}} + (ACC_W+DEG_W)'(DEG_FULL / 2);
    return ACC_W'(num / (ACC_W+DEG_W)'(DEG_FULL));
  endfunction
endpackage

// File: rtl/dds_ctrl_regs.sv
module dds_ctrl_regs
  import dds_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [ACC_W-1:0] wr_data_i,
  input  logic             apply_i,
  output logic [ACC_W-1:0] tune_o,
  output logic [ACC_W-1:0] ofs_o,
  output logic [ACC_W-1:0] ofs_next_o,
  output logic [AMP_W-1:0] amp_o,
  output logic [DEG_W-1:0] deg_shd_o
);
  logic [ACC_W-1:0] tune_shd;
  logic [DEG_W-1:0] deg_shd;
  logic [AMP_W-1:0] amp_shd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tune_shd <= '0;
      deg_shd  <= '0;
      amp_shd  <= '1;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        REG_TUNE: tune_shd <= wr_data_i;
        REG_DEG:  if (wr_data_i < ACC_W'(DEG_FULL)) deg_shd <= wr_data_i[DEG_W-1:0];
        REG_AMP:  amp_shd <= wr_data_i[AMP_W-1:0];
        default:  ;
      endcase
    end
  end

  assign ofs_next_o = deg_to_ofs(deg_shd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tune_o <= '0;
      ofs_o  <= '0;
      amp_o  <= '1;
    end else if (apply_i) begin
      tune_o <= tune_shd;
      ofs_o  <= ofs_next_o;
      amp_o  <= amp_shd;
    end
  end

  assign deg_shd_o = deg_shd;
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (load_i) acc_o <= load_val_i;
    else             acc_o <= acc_o + step_i;
  end
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [DW-1:0] sin_pt(input int idx);
    real ph, v;
    ph = 2.0 * 3.14159265358979323846 * real'(idx) / real'(DEPTH);
    v  = (2.0 ** (DW-1)) + ((2.0 ** (DW-1)) - 1.0) * $sin(ph);
    return DW'($rtoi(v + 0.5));
  endfunction

  logic [DW-1:0] lut [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lut
    localparam logic [DW-1:0] VAL = sin_pt(i);
    assign lut[i] = VAL;
  end

  assign data_o = lut[addr_i];
endmodule

// File: rtl/dds_amp_scale.sv
module dds_amp_scale #(
  parameter int DW    = 8,
  parameter int AMP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    samp_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic [DW-1:0]    samp_o
);
  localparam int PW = DW + AMP_W + 2;
  localparam logic signed [PW-1:0] MID = PW'(1) << (DW - 1);

  logic signed [PW-1:0] diff, prod, res;

  always_comb begin
    diff = $signed(PW'(samp_i)) - MID;
    prod = diff * $signed(PW'(amp_i));
    res  = (prod >>> AMP_W) + MID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) samp_o <= DW'(MID);
    else         samp_o <= DW'(res);
  end
endmodule

// File: rtl/dual_dds_core.sv
module dual_dds_core
  import dds_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [ACC_W-1:0]  wr_data_i,
  input  logic              apply_i,
  output logic [SAMP_W-1:0] samp_a_o,
  output logic [SAMP_W-1:0] samp_b_o
);
  localparam int NCH = 2;

  logic [ACC_W-1:0]  tune_act, ofs_act, ofs_next;
  logic [AMP_W-1:0]  amp_act;
  logic [DEG_W-1:0]  deg_shd;
  logic [ACC_W-1:0]  acc      [NCH];
  logic [ACC_W-1:0]  load_val [NCH];
  logic [SAMP_W-1:0] samp     [NCH];

  dds_ctrl_regs u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .apply_i    (apply_i),
    .tune_o     (tune_act),
    .ofs_o      (ofs_act),
    .ofs_next_o (ofs_next),
    .amp_o      (amp_act),
    .deg_shd_o  (deg_shd)
  );

  // channel 0 restarts at zero, channel 1 at the degree offset
  assign load_val[0] = '0;
  assign load_val[1] = ofs_next;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SAMP_W-1:0] tbl;

    dds_phase_acc #(.W(ACC_W)) u_acc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (apply_i),
      .load_val_i (load_val[c]),
      .step_i     (tune_act),
      .acc_o      (acc[c])
    );

    dds_sine_rom #(.AW(LUT_AW), .DW(SAMP_W)) u_rom (
      .addr_i (acc[c][ACC_W-1 -: LUT_AW]),
      .data_o (tbl)
    );

    dds_amp_scale #(.DW(SAMP_W), .AMP_W(AMP_W)) u_scl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .samp_i (tbl),
      .amp_i  (amp_act),
      .samp_o (samp[c])
    );
  end

  assign samp_a_o = samp[0];
  assign samp_b_o = samp[1];
endmodule

// File: rtl/dual_dds_chk.sv
module dual_dds_chk
  import dds_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              apply_i,
  input logic [ACC_W-1:0]  acc_a,
  input logic [ACC_W-1:0]  acc_b,
  input logic [ACC_W-1:0]  tune_act,
  input logic [ACC_W-1:0]  ofs_act,
  input logic [AMP_W-1:0]  amp_act,
  input logic [DEG_W-1:0]  deg_shd,
  input logic [SAMP_W-1:0] samp_a_o,
  input logic [SAMP_W-1:0] samp_b_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  p_acc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    !$past(apply_i) |-> acc_a == ACC_W'($past(acc_a) + $past(tune_act)));

  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |=> (acc_a == '0) && (acc_b == ofs_act));

  p_deg_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deg_shd < DEG_W'(DEG_FULL));

  p_mute_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_act == '0 |=> (samp_a_o == SAMP_W'(128)) && (samp_b_o == SAMP_W'(128)));

  p_const_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    !$past(apply_i) |-> ACC_W'(acc_b - acc_a) == ACC_W'($past(acc_b) - $past(acc_a)));
endmodule

bind dual_dds_core dual_dds_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .apply_i  (apply_i),
  .acc_a    (acc[0]),
  .acc_b    (acc[1]),
  .tune_act (tune_act),
  .ofs_act  (ofs_act),
  .amp_act  (amp_act),
  .deg_shd  (deg_shd),
  .samp_a_o (samp_a_o),
  .samp_b_o (samp_b_o)
);

// File: tb/tb_dual_dds_core.sv
`timescale 1ns/1ps
module tb_dual_dds_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        apply_i = 1'b0;
  logic [7:0]  samp_a_o, samp_b_o;

  dual_dds_core dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int lut [256];

  // bench shadow and active model
  logic [31:0] s_k = 0, m_k = 0, m_a = 0, m_b = 0;
  int s_deg = 0, s_amp = 255, m_amp = 255;
  int hist [300];

  // {tune 32, degrees 9, amplitude 8}
  localparam logic [48:0] VEC [6] = '{
    {32'h0100_0000, 9'd0,   8'd255},
    {32'h0123_4567, 9'd90,  8'd255},
    {32'h0800_0000, 9'd180, 8'd128},
    {32'hFFF0_0000, 9'd359, 8'd200},
    {32'h0000_A7C6, 9'd1,   8'd255},
    {32'h0040_0000, 9'd45,  8'd0}
  };

  function automatic int scl(int t, int a);
    int p;
    p = (t - 128) * a;
    return (p >>> 8) + 128;
  endfunction

  function automatic logic [31:0] ofs_of(int d);
    longint unsigned num;
    num = longint'(d) * 64'h1_0000_0000 + 64'd180;
    return 32'(num / 64'd360);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    wr_en_i = 1; wr_addr_i = 2'(addr); wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 0;
    case (addr)
      0: s_k = data;
      1: if (data < 360) s_deg = int'(data);
      2: s_amp = int'(data[7:0]);
      default: ;
    endcase
  endtask

  task automatic apply();
    apply_i = 1;
    @(negedge clk_i);
    apply_i = 0;
    m_k = s_k; m_amp = s_amp; m_a = 0; m_b = ofs_of(s_deg);
  endtask

  // compare n samples against the model; rec stores channel A history
  task automatic run(int n, string req, bit rec);
    for (int i = 0; i < n; i++) begin
      int ea, eb;
      @(negedge clk_i);
      ea = scl(lut[m_a[31:24]], m_amp);
      eb = scl(lut[m_b[31:24]], m_amp);
      chk(samp_a_o == 8'(ea), req, samp_a_o, ea);
      chk(samp_b_o == 8'(eb), req, samp_b_o, eb);
      if (rec && i < 300) hist[i] = samp_a_o;
      m_a += m_k; m_b += m_k;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++)
      lut[i] = $rtoi(128.0 + 127.0 * $sin(2.0 * 3.14159265358979323846 * i / 256.0) + 0.5);

    // R1 during and after reset
    repeat (3) @(negedge clk_i);
    chk(samp_a_o == 8'd128, "R1", samp_a_o, 128);
    chk(samp_b_o == 8'd128, "R1", samp_b_o, 128);
    rst_ni = 1;
    run(8, "R1", 0);

    // vector table: R3 R4 R5 R7 R8
    foreach (VEC[v]) begin
      wr(0, VEC[v][48:17]);
      wr(1, 32'(VEC[v][16:8]));
      wr(2, 32'(VEC[v][7:0]));
      apply();
      run(v == 0 ? 300 : 64, "R4_R5_R7_R8", v == 0);
      if (v == 0)
        for (int i = 0; i < 44; i++)
          chk(hist[i] == hist[i+256], "R3 period", hist[i+256], hist[i]);
    end

    // R2: writes without apply leave outputs unchanged; address 3 ignored
    wr(0, 32'h0321_0000);
    wr(1, 32'd10);
    wr(2, 32'd255);
    wr(3, 32'hFFFF_FFFF);
    run(3, "R2", 0);
    apply();
    run(40, "R2", 0);

    // R6: out-of-range degrees dropped
    wr(1, 32'd90);
    wr(1, 32'd360);
    wr(1, 32'd511);
    wr(1, 32'h8000_005A);
    apply();
    chk(m_b == ofs_of(90), "R6 model", int'(m_b), int'(ofs_of(90)));
    run(64, "R6", 0);

    // R5: write and apply on the same edge, apply uses old shadow
    wr_en_i = 1; wr_addr_i = 2'd1; wr_data_i = 32'd200;
    apply_i = 1;
    @(negedge clk_i);
    wr_en_i = 0; apply_i = 0;
    m_k = s_k; m_amp = s_amp; m_a = 0; m_b = ofs_of(s_deg);
    s_deg = 200;
    run(32, "R5 same-edge", 0);
    apply();
    run(32, "R5", 0);

    // R7: amplitude 0 mutes, then amplitude 1
    wr(2, 32'd0); apply(); run(20, "R7", 0);
    wr(2, 32'd1); apply(); run(20, "R7", 0);

    // R1: reset mid-run, R1/R5 apply after reset uses reset shadows
    rst_ni = 0;
    #1;
    chk(samp_a_o == 8'd128, "R1 async", samp_a_o, 128);
    chk(samp_b_o == 8'd128, "R1 async", samp_b_o, 128);
    @(negedge clk_i);
    rst_ni = 1;
    s_k = 0; s_deg = 0; s_amp = 255; m_k = 0; m_amp = 255; m_a = 0; m_b = 0;
    run(6, "R1", 0);
    apply();
    run(6, "R1", 0);
    wr(0, 32'h0200_0000); apply(); run(48, "R3", 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule